// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a behavioral model of a flow-through synchronous burst SRAM. Each word holds `BYTES` lanes of `BW` bits. With the defaults a lane is 8 data bits plus one parity bit, and a word has two lanes. On every rising clock edge the block samples the address, three chip selects, two address-start strobes, an advance input and the write controls. From these it classifies the cycle as one of four kinds: deselect, start with an external address, step to the next burst address, or hold at the current burst address. A write lands in the array on the edge that samples it. A read drives the array word for the sampled address during the clock period that follows that edge, with no output register.

There are two address-start strobes, and they differ:
- The processor strobe is qualified by the primary select and always begins a read.
- The controller strobe begins a read or a write according to the write controls.

A write can follow a processor-started read in the next hold (wait) cycle. A 2-bit burst counter walks the four addresses of an aligned group, in either linear or interleaved order.

The data path is a plain memory port and carries no valid/ready handshake. A host may treat `rdata_oe` as the valid qualifier of `rdata`. There is no back-pressure: a read word is visible for exactly one clock period. The output enable and the sleep input act without waiting for a clock edge.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset `rdata_oe` is 0 and no burst is live, so a step or hold cycle before the first start reads and writes nothing.
- R2: A cycle is deselected when `ctrl_start_n` is low while `sel_n` is high, or when either strobe is effectively low while `sel_hi` is low or `sel2_n` is high. A deselected cycle forces `rdata_oe` to 0 and ends the live burst.
- R3: While `sel_n` is high, `proc_start_n` is ignored. The cycle is then classified from `ctrl_start_n` and `advance_n` alone.
- R4: A selected cycle with `proc_start_n` low loads `addr` and reads it, even when the write controls request a write. The array is left unchanged.
- R5: A selected cycle with `proc_start_n` high and `ctrl_start_n` low loads `addr`. It writes when the write controls request a write and reads otherwise.
- R6: With both strobes high and `advance_n` low, a live burst steps to the next address. The upper address bits stay fixed and the low 2 bits follow the start offset s at step k. With `seq_linear`=1 they are (s+k) mod 4. With `seq_linear`=0 they are s XOR k.
- R7: With both strobes high and `advance_n` high, a live burst holds its current address. The cycle reads, or writes that address when a write is requested.
- R8: Write mask decoding works as follows. `all_wr_n`=0 writes every lane. Otherwise, if `byte_wr_n`=0, lane b is written when `wr_byte_n[b]`=0. Otherwise the cycle is a read. Lane b occupies word bits [b*9+8 : b*9], with bit b*9+8 as that lane's parity bit.
- R9: `rdata_oe` equals the registered read-valid flag ANDed with the inverse of `out_en_n`, and follows `out_en_n` without a clock edge. The read-valid flag is 0 after write and deselect cycles.
- R10: While `snooze` is high, a clock edge performs no access: no write, no change of burst state, and `rdata_oe` is 0 after that edge. A step after waking continues from the address used before sleep.
- R11: The read data for the address used at an edge is on `rdata` within the same clock period, with no added latency.
- R12: A step or hold cycle after a deselect, with no new start, neither writes nor drives data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | External word address |
| sel_n | input | 1 | Primary select, active low, qualifies the processor strobe |
| sel_hi | input | 1 | Depth select, active high |
| sel2_n | input | 1 | Depth select, active low |
| proc_start_n | input | 1 | Processor address-start strobe, active low, read only |
| ctrl_start_n | input | 1 | Controller address-start strobe, active low |
| advance_n | input | 1 | Low steps the burst, high holds it |
| all_wr_n | input | 1 | Write all lanes, active low |
| byte_wr_n | input | 1 | Enables the per-lane write controls, active low |
| wr_byte_n | input | BYTES | Per-lane write selects, active low, bit 0 is the low lane |
| seq_linear | input | 1 | 1 selects linear burst order, 0 selects interleaved |
| wdata | input | BYTES*BW | Write data |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| snooze | input | 1 | Sleep: ignore accesses while high |
| rdata | output | BYTES*BW | Read data (flow-through) |
| rdata_oe | output | 1 | Output drive enable for `rdata` |

## Verification
Most faults in the internal state show up at the ports within one clock period, because the read path has no pipeline. A wrong burst counter or burst order shows as a wrong word on the step cycle where the address diverges. A stale live-burst flag shows as `rdata_oe` rising on a step right after a deselect. A wrong lane mask stays hidden in the array until that word is read back, so every write in the sweeps is followed by a controller-start read of the same address, and the lane and parity bits are compared exactly.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [1:0] {
    CYC_DESEL = 2'd0,
    CYC_LOAD  = 2'd1,
    CYC_NEXT  = 2'd2,
    CYC_HOLD  = 2'd3
  } cyc_e;
endpackage

// File: rtl/sbs_cycle_decode.sv
module sbs_cycle_decode
  import sbs_pkg::*;
#(
  parameter int BYTES = 2
) (
  input  logic             sel_n,
  input  logic             sel_hi,
  input  logic             sel2_n,
  input  logic             proc_start_n,
  input  logic             ctrl_start_n,
  input  logic             advance_n,
  input  logic             all_wr_n,
  input  logic             byte_wr_n,
  input  logic [BYTES-1:0] wr_byte_n,
  output cyc_e             kind,
  output logic [BYTES-1:0] wr_mask
);
  logic proc_go, ctrl_go, chip_on;
  logic [BYTES-1:0] req_mask;

  // processor strobe only counts when the primary select is low
  assign proc_go = !proc_start_n && !sel_n;
  assign ctrl_go = !ctrl_start_n;
  assign chip_on = !sel_n && sel_hi && !sel2_n;

  always_comb begin
    if (!all_wr_n)       req_mask = '1;
    else if (!byte_wr_n) req_mask = ~wr_byte_n;
    else                 req_mask = '0;
  end

  always_comb begin
    if (proc_go || ctrl_go) kind = chip_on ? CYC_LOAD : CYC_DESEL;
    else                    kind = advance_n ? CYC_HOLD : CYC_NEXT;
  end

  // a processor start is always a read; a deselect never writes
  always_comb begin
    if (kind == CYC_DESEL || (kind == CYC_LOAD && proc_go)) wr_mask = '0;
    else                                                    wr_mask = req_mask;
  end
endmodule

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq #(
  parameter int AW = 6,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          seq_linear,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] use_addr
);
  localparam int UW = AW - CW;

  logic [UW-1:0] upper_q;
  logic [CW-1:0] start_q, cnt_q, cnt_d, low_d;

  always_comb begin
    if (load)      cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
    else           cnt_d = cnt_q;
  end

  always_comb begin
    if (seq_linear) low_d = start_q + cnt_d;
    else            low_d = start_q ^ cnt_d;
  end

  assign use_addr = load ? ext_addr : {upper_q, low_d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      start_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (load) begin
        upper_q <= ext_addr[AW-1:CW];
        start_q <= ext_addr[CW-1:0];
      end
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/sbs_byte_array.sv
module sbs_byte_array #(
  parameter int AW    = 6,
  parameter int BYTES = 2,
  parameter int BW    = 9
) (
  input  logic                clk,
  input  logic [BYTES-1:0]    we,
  input  logic [AW-1:0]       waddr,
  input  logic [BYTES*BW-1:0] wdata,
  input  logic [AW-1:0]       raddr,
  output logic [BYTES*BW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int WW    = BYTES * BW;

  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int b = 0; b < BYTES; b++) begin
      if (we[b]) mem[waddr][b*BW +: BW] <= wdata[b*BW +: BW];
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int AW    = 6,
  parameter int CW    = 2,
  parameter int BYTES = 2,
  parameter int BW    = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       addr,
  input  logic                sel_n,
  input  logic                sel_hi,
  input  logic                sel2_n,
  input  logic                proc_start_n,
  input  logic                ctrl_start_n,
  input  logic                advance_n,
  input  logic                all_wr_n,
  input  logic                byte_wr_n,
  input  logic [BYTES-1:0]    wr_byte_n,
  input  logic                seq_linear,
  input  logic [BYTES*BW-1:0] wdata,
  input  logic                out_en_n,
  input  logic                snooze,
  output logic [BYTES*BW-1:0] rdata,
  output logic                rdata_oe
);
  cyc_e             kind;
  logic [BYTES-1:0] wr_mask, we;
  logic [AW-1:0]    use_addr, rd_addr_q;
  logic             live_q, rd_valid_q;
  logic             awake, do_load, do_step, access;

  sbs_cycle_decode #(.BYTES(BYTES)) u_dec (
    .sel_n(sel_n), .sel_hi(sel_hi), .sel2_n(sel2_n),
    .proc_start_n(proc_start_n), .ctrl_start_n(ctrl_start_n),
    .advance_n(advance_n), .all_wr_n(all_wr_n), .byte_wr_n(byte_wr_n),
    .wr_byte_n(wr_byte_n), .kind(kind), .wr_mask(wr_mask)
  );

  assign awake   = !snooze;
  assign do_load = awake && (kind == CYC_LOAD);
  assign do_step = awake && (kind == CYC_NEXT) && live_q;
  assign access  = do_load ||
                   (awake && live_q && (kind == CYC_NEXT || kind == CYC_HOLD));
  assign we      = access ? wr_mask : '0;

  sbs_burst_seq #(.AW(AW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(do_load), .step(do_step),
    .seq_linear(seq_linear), .ext_addr(addr), .use_addr(use_addr)
  );

  sbs_byte_array #(.AW(AW), .BYTES(BYTES), .BW(BW)) u_arr (
    .clk(clk), .we(we), .waddr(use_addr), .wdata(wdata),
    .raddr(rd_addr_q), .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q     <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_addr_q  <= '0;
    end else if (!awake) begin
      rd_valid_q <= 1'b0;
    end else if (kind == CYC_DESEL) begin
      live_q     <= 1'b0;
      rd_valid_q <= 1'b0;
    end else if (access) begin
      live_q     <= 1'b1;
      rd_valid_q <= (wr_mask == '0);
      rd_addr_q  <= use_addr;
    end else begin
      rd_valid_q <= 1'b0;
    end
  end

  assign rdata_oe = rd_valid_q && !out_en_n;

  // R9: a cycle that wrote never drives data in the period after it
  a_r9_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (|we) |=> !rdata_oe);

  // R2: a deselect ends the burst and silences the outputs
  a_r2_deselect_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (awake && kind == CYC_DESEL) |=> (!live_q && !rd_valid_q));

  // R10: sleeping edges leave nothing valid
  a_r10_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    snooze |=> !rd_valid_q);

  // R12: step or hold without a live burst does nothing
  a_r12_dead_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (awake && !live_q && (kind == CYC_NEXT || kind == CYC_HOLD)) |=>
    (!rd_valid_q && !live_q));

  // R7: a hold keeps the address of the previous access
  a_r7_hold_same: assert property (@(posedge clk) disable iff (!rst_n)
    (awake && live_q && kind == CYC_HOLD) |=> (rd_addr_q == $past(rd_addr_q)));

  // R6: a step moves within the aligned group
  a_r6_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
    do_step |=> ((rd_addr_q != $past(rd_addr_q)) &&
                 (rd_addr_q[AW-1:CW] == $past(rd_addr_q[AW-1:CW]))));
endmodule

// File: tb/sync_burst_sram_bench.sv
module sync_burst_sram_bench;
  localparam int AW = 6;
  localparam int WW = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic sn = 1'b0, sh = 1'b1, s2n = 1'b0;
  logic pn = 1'b1, cn = 1'b1, avn = 1'b1;
  logic gwn = 1'b1, bwn = 1'b1;
  logic [1:0] wbn = 2'b11;
  logic lin = 1'b1, oen = 1'b0, slp = 1'b0;
  logic [WW-1:0] wd = '0;
  logic [WW-1:0] rdata;
  logic rdata_oe;

  int checks = 0;
  int errors = 0;
  logic [WW-1:0] em [64];

  always #2 clk = ~clk;

  sync_burst_sram u_sync_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sn), .sel_hi(sh),
    .sel2_n(s2n), .proc_start_n(pn), .ctrl_start_n(cn), .advance_n(avn),
    .all_wr_n(gwn), .byte_wr_n(bwn), .wr_byte_n(wbn), .seq_linear(lin),
    .wdata(wd), .out_en_n(oen), .snooze(slp), .rdata(rdata),
    .rdata_oe(rdata_oe)
  );

  function automatic logic [WW-1:0] pat(int a);
    return WW'(a * 4129 + 1000 + (a << 11));
  endfunction

  task automatic chk_oe(string tag, logic exp);
    checks++;
    if (rdata_oe !== exp) begin
      errors++;
      $display("FAIL %s rdata_oe got %0b exp %0b", tag, rdata_oe, exp);
    end
  endtask

  task automatic chk_rd(string tag, logic [WW-1:0] exp);
    checks++;
    if (rdata_oe !== 1'b1 || rdata !== exp) begin
      errors++;
      $display("FAIL %s oe %0b data got %h exp %h", tag, rdata_oe, rdata, exp);
    end
  endtask

  // drive one cycle at the falling edge, sample 1 ns after the rising edge
  task automatic cyc(logic p, logic c, logic av, logic g, logic bw,
                     logic [1:0] wb, logic [AW-1:0] a, logic [WW-1:0] d);
    @(negedge clk);
    pn = p; cn = c; avn = av; gwn = g; bwn = bw; wbn = wb; addr = a; wd = d;
    @(posedge clk);
    #1;
  endtask

  task automatic ctrl_rd(logic [AW-1:0] a);
    cyc(1, 0, 1, 1, 1, 2'b11, a, '0);
  endtask

  task automatic ctrl_wr(logic [AW-1:0] a, logic [WW-1:0] d);
    cyc(1, 0, 1, 0, 1, 2'b11, a, d);
    em[a] = d;
  endtask

  task automatic idle();
    @(negedge clk);
    pn = 1; cn = 1; avn = 1; gwn = 1; bwn = 1; wbn = 2'b11;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk_oe("R1 reset", 1'b0);
    rst_n = 1'b1;
    // R1: hold with a write request before any start writes nothing
    cyc(1, 1, 1, 0, 1, 2'b11, 6'd0, 18'h3ffff);
    chk_oe("R1 no burst", 1'b0);

    // R5/R8: fill every word with an all-lanes write, then read back (R11)
    for (int a = 0; a < 64; a++) begin
      ctrl_wr(6'(a), pat(a));
      chk_oe("R5 write cycle", 1'b0);
    end
    for (int a = 0; a < 64; a++) begin
      ctrl_rd(6'(a));
      chk_rd("R11 R5 read", em[a]);
    end

    // R6: bursts from each start offset in both orders, R4 processor start
    for (int m = 0; m < 2; m++) begin
      lin = m[0];
      for (int s = 0; s < 4; s++) begin
        cyc(0, 1, 1, 1, 1, 2'b11, 6'h14 | 6'(s), '0);
        chk_rd("R4 start", em[6'h14 | s]);
        for (int k = 1; k < 4; k++) begin
          cyc(1, 1, 0, 1, 1, 2'b11, 6'h00, '0);
          if (lin) chk_rd("R6 linear", em[{4'h5, 2'(s + k)}]);
          else     chk_rd("R6 interleave", em[{4'h5, 2'(s ^ k)}]);
        end
      end
    end
    lin = 1'b1;

    // R4: processor start with write controls still reads, array untouched
    cyc(0, 1, 1, 0, 0, 2'b00, 6'd7, 18'h2aaaa);
    chk_rd("R4 forced read", em[7]);
    ctrl_rd(6'd7);
    chk_rd("R4 unchanged", em[7]);

    // R7: hold reads the same word, then a write in the wait cycle
    cyc(0, 1, 1, 1, 1, 2'b11, 6'h2a, '0);
    chk_rd("R7 start", em[6'h2a]);
    cyc(1, 1, 1, 1, 1, 2'b11, 6'h00, '0);
    chk_rd("R7 hold read", em[6'h2a]);
    cyc(1, 1, 1, 0, 1, 2'b11, 6'h00, 18'h1c3a5);
    em[6'h2a] = 18'h1c3a5;
    chk_oe("R7 hold write", 1'b0);
    ctrl_rd(6'h2a);
    chk_rd("R7 readback", em[6'h2a]);

    // R8: every byte_wr_n / wr_byte_n combination with all_wr_n high
    for (int k = 0; k < 8; k++) begin
      logic [WW-1:0] nd, old, exp;
      logic [1:0] m;
      nd  = pat(k + 100) ^ 18'h3ffff;
      old = em[9];
      m   = k[2] ? 2'b00 : ~k[1:0];
      exp = old;
      if (m[0]) exp[8:0]  = nd[8:0];
      if (m[1]) exp[17:9] = nd[17:9];
      cyc(1, 0, 1, 1, k[2], k[1:0], 6'd9, nd);
      if (m == 2'b00) chk_rd("R8 read combo", old);
      else            chk_oe("R8 write combo", 1'b0);
      em[9] = exp;
      ctrl_rd(6'd9);
      chk_rd("R8 lane merge", exp);
    end
    // R8: all_wr_n low overrides byte_wr_n high
    cyc(1, 0, 1, 0, 1, 2'b11, 6'd9, 18'h0f0f0);
    em[9] = 18'h0f0f0;
    ctrl_rd(6'd9);
    chk_rd("R8 all lanes", em[9]);

    // R9: output enable acts between edges
    oen = 1'b1;
    ctrl_rd(6'd3);
    chk_oe("R9 disabled", 1'b0);
    oen = 1'b0;
    #1;
    chk_rd("R9 async enable", em[3]);
    oen = 1'b1;
    #1;
    chk_oe("R9 async disable", 1'b0);
    oen = 1'b0;

    // R2/R12: five deselect patterns, each followed by a stray step write
    for (int v = 0; v < 5; v++) begin
      cyc(0, 1, 1, 1, 1, 2'b11, 6'h20, '0);
      chk_rd("R2 setup", em[6'h20]);
      @(negedge clk);
      case (v)
        0: begin sn = 1; pn = 1; cn = 0; end
        1: begin sh = 0; pn = 1; cn = 0; end
        2: begin s2n = 1; pn = 1; cn = 0; end
        3: begin sh = 0; pn = 0; cn = 1; end
        default: begin s2n = 1; pn = 0; cn = 1; end
      endcase
      avn = 1; gwn = 1; bwn = 1; addr = 6'h20;
      @(posedge clk);
      #1;
      chk_oe("R2 deselect", 1'b0);
      sn = 0; sh = 1; s2n = 0;
      cyc(1, 1, 0, 0, 1, 2'b11, 6'h20, 18'h3ffff);
      chk_oe("R12 dead step", 1'b0);
      cyc(1, 1, 1, 1, 1, 2'b11, 6'h20, '0);
      chk_oe("R12 dead hold", 1'b0);
    end
    ctrl_rd(6'h20);
    chk_rd("R12 no write 20", em[6'h20]);
    ctrl_rd(6'h21);
    chk_rd("R12 no write 21", em[6'h21]);

    // R3: processor strobe with primary select high acts as step/hold
    cyc(0, 1, 1, 1, 1, 2'b11, 6'h30, '0);
    chk_rd("R3 setup", em[6'h30]);
    sn = 1'b1;
    cyc(0, 1, 0, 1, 1, 2'b11, 6'h05, '0);
    chk_rd("R3 ignored step", em[6'h31]);
    cyc(0, 1, 1, 1, 1, 2'b11, 6'h05, '0);
    chk_rd("R3 ignored hold", em[6'h31]);
    sn = 1'b0;

    // R10: sleep blocks a write and freezes the burst
    cyc(0, 1, 1, 1, 1, 2'b11, 6'h34, '0);
    chk_rd("R10 setup", em[6'h34]);
    cyc(1, 1, 0, 1, 1, 2'b11, 6'h00, '0);
    chk_rd("R10 step", em[6'h35]);
    slp = 1'b1;
    cyc(1, 1, 0, 1, 1, 2'b11, 6'h00, '0);
    chk_oe("R10 asleep step", 1'b0);
    cyc(1, 0, 1, 0, 1, 2'b11, 6'h11, 18'h12345);
    chk_oe("R10 asleep write", 1'b0);
    slp = 1'b0;
    cyc(1, 1, 0, 1, 1, 2'b11, 6'h00, '0);
    chk_rd("R10 resume", em[6'h36]);
    ctrl_rd(6'h11);
    chk_rd("R10 no write", em[6'h11]);

    idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule